// File: doc/BRIEF.md
# Resynchronization Phase Calibration Sweeper

This block tunes the clock phase that re-times captured read data in a source-synchronous memory read path. It runs once at start-up, before ordinary read and write traffic may begin. Over one full clock cycle it tries each candidate phase in turn. The phase step is set by parameter: 15 degrees by default, which gives 24 candidates. For each candidate it asks the clock generator to move to that phase and waits for the change to be confirmed. It then lets the new phase settle, reads a known training pattern back, and checks every DQ pin of the group against the expected bits.

Each pin gets its own pass or fail mark for every phase, and all of them are stored. A phase counts as good only when every pin passes at it. After the last phase, the block finds the longest unbroken run of good phases on the circular phase scale, including a run that wraps from the top index back to zero. It commands the phase at the middle of that run, which gives equal setup and hold margin, and reports completion. If no phase is good, it commands phase zero and raises an error flag together with completion.

Top module: `phase_cal_sweeper`

## Requirements
- R1: After reset, phase_req, rd_req, busy, cal_done and cal_error are low and phase_sel is 0.
- R2: A cal_start pulse seen while idle or done starts a sweep. The sweep issues phase commands 0, 1, ..., PHASES-1 in that order. Each command holds phase_req high, with phase_sel unchanged, until phase_ack is sampled high. busy is high and cal_done is low from the cycle after the start.
- R3: For each phase, exactly one rd_req pulse of one cycle is issued. It comes exactly SETTLE_CYC+1 cycles after the cycle in which phase_ack was accepted, and never while phase_req is high.
- R4: Pin p is judged on bits rd_data[p*BEATS +: BEATS], which are compared with exp_pattern[p*BEATS +: BEATS]. The result is taken in the cycle rd_valid is high after rd_req. A phase is good only if all PINS slices match.
- R5: The chosen window is the longest run of consecutive good phases. The run may wrap from phase PHASES-1 to phase 0. If every phase is good, the window starts at 0 and has length PHASES.
- R6: The applied phase is (first + (length-1)/2) mod PHASES. Among windows of equal length, the one with the lowest first index wins; a wrapping window's first index is its index above the wrap.
- R7: After the sweep, one more phase command carries the chosen phase. When it is acknowledged, cal_done goes high and busy goes low, and cal_done stays high until the next start.
- R8: If no phase is good, the final phase command carries 0 and cal_error is high together with cal_done.
- R9: cal_start is ignored while busy. The sweep does not restart, and no more than PHASES+1 phase commands are issued.
- R10: rd_valid is ignored unless the block is waiting for read data after an rd_req. Read data arriving at any other time does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start | input | 1 | Start pulse for a calibration run |
| phase_req | output | 1 | Phase change request to the clock generator |
| phase_sel | output | $clog2(PHASES) | Requested or applied phase index |
| phase_ack | input | 1 | Clock generator confirms the phase change |
| rd_req | output | 1 | Single-cycle request for one training read |
| rd_valid | input | 1 | Training read data present |
| rd_data | input | PINS*BEATS | Returned read data, BEATS bits per pin |
| exp_pattern | input | PINS*BEATS | Expected training pattern, same layout |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration finished, final phase applied |
| cal_error | output | 1 | No phase was good |

## Verification
Two events can fall in the same cycle: a new cal_start and the recording of the last phase's read result. The bench raises cal_start in the exact cycle the final read data is returned. It also raises it once mid-sweep. It judges the outcome by counting phase commands, which must be exactly PHASES+1 and in order, and by checking the applied phase. A second overlap comes from stray read data that the bench injects during each settle window. If that data were recorded, it would corrupt the map and move the chosen phase, so the bench compares the final phase with the value it computes from its own per-pin masks.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET,
    ST_SETTLE,
    ST_REQ,
    ST_WAIT,
    ST_PICK,
    ST_APPLY,
    ST_DONE
  } cal_state_t;

  // first index of a circular run given its last index and length
  function automatic int ring_first(int last, int len, int n);
    return (last + n - len + 1) % n;
  endfunction

  // middle of a circular run, rounding toward its first index
  function automatic int ring_centre(int first, int len, int n);
    int half;
    half = (len > 0) ? (len - 1) / 2 : 0;
    return (first + half) % n;
  endfunction

endpackage

// File: rtl/rsc_compare.sv
module rsc_compare #(
  parameter int PINS  = 8,
  parameter int BEATS = 8
) (
  input  logic [PINS*BEATS-1:0] rd_data,
  input  logic [PINS*BEATS-1:0] exp_data,
  output logic [PINS-1:0]       pin_ok
);

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_lane
      assign pin_ok[p] = (rd_data[p*BEATS +: BEATS] == exp_data[p*BEATS +: BEATS]);
    end
  endgenerate

endmodule

// File: rtl/rsc_passmap.sv
module rsc_passmap #(
  parameter int PHASES = 24,
  parameter int PINS   = 8,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [PH_W-1:0]   wr_idx,
  input  logic [PINS-1:0]   pin_ok,
  output logic [PHASES-1:0] phase_pass
);

  genvar i;
  generate
    for (i = 0; i < PHASES; i++) begin : g_row
      logic [PINS-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q <= '0;
        end else if (clear) begin
          row_q <= '0;
        end else if (wr_en && (wr_idx == PH_W'(i))) begin
          row_q <= pin_ok;
        end
      end
      assign phase_pass[i] = &row_q;
    end
  endgenerate

endmodule

// File: rtl/rsc_window.sv
module rsc_window
  import rsc_pkg::*;
#(
  parameter int PHASES = 24,
  localparam int PH_W  = $clog2(PHASES),
  localparam int LEN_W = $clog2(PHASES + 1)
) (
  input  logic [PHASES-1:0] phase_pass,
  output logic              found,
  output logic [PH_W-1:0]   centre
);

  logic [LEN_W-1:0] run_len;
  logic [LEN_W-1:0] best_len;
  logic [PH_W-1:0]  best_end;
  logic [PH_W-1:0]  win_first;

  // two laps around the ring so a run crossing the top index is seen whole;
  // strict comparison keeps the earliest-ending run on ties
  always_comb begin
    run_len  = '0;
    best_len = '0;
    best_end = '0;
    for (int k = 0; k < 2 * PHASES; k++) begin
      if (phase_pass[k % PHASES]) begin
        if (run_len != LEN_W'(PHASES)) run_len = run_len + 1'b1;
      end else begin
        run_len = '0;
      end
      if (run_len > best_len) begin
        best_len = run_len;
        best_end = PH_W'(k % PHASES);
      end
    end
  end

  assign found     = (best_len != '0);
  assign win_first = PH_W'(ring_first(int'(best_end), int'(best_len), PHASES));
  assign centre    = PH_W'(ring_centre(int'(win_first), int'(best_len), PHASES));

endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int PHASES     = 24,
  parameter int SETTLE_CYC = 4,
  localparam int PH_W      = $clog2(PHASES),
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            phase_ack,
  input  logic            rd_valid,
  input  logic            found,
  input  logic [PH_W-1:0] centre,
  output logic            phase_req,
  output logic [PH_W-1:0] phase_sel,
  output logic            rd_req,
  output logic            busy,
  output logic            done,
  output logic            error,
  output logic            map_clear,
  output logic            map_wr,
  output logic [PH_W-1:0] map_idx,
  output logic            ev_ack,
  output logic            ev_record,
  output logic            sweep_active
);

  cal_state_t       state_q;
  logic [PH_W-1:0]  idx_q;
  logic [PH_W-1:0]  sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             err_q;
  logic             start_ok;
  logic             last_phase;
  logic             settle_end;

  assign phase_req    = (state_q == ST_SET) || (state_q == ST_APPLY);
  assign rd_req       = (state_q == ST_REQ);
  assign busy         = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign sweep_active = (state_q == ST_SET) || (state_q == ST_SETTLE) ||
                        (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign start_ok     = start && !busy;
  assign ev_ack       = phase_req && phase_ack;
  assign ev_record    = (state_q == ST_WAIT) && rd_valid;
  assign last_phase   = (idx_q == PH_W'(PHASES - 1));
  assign settle_end   = (cnt_q == CNT_W'(SETTLE_CYC - 1));

  assign phase_sel = sel_q;
  assign done      = done_q;
  assign error     = err_q;
  assign map_clear = start_ok;
  assign map_wr    = ev_record;
  assign map_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sel_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            idx_q   <= '0;
            sel_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            state_q <= ST_SET;
          end
        end
        ST_SET: begin
          if (phase_ack) begin
            cnt_q   <= '0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (settle_end) state_q <= ST_REQ;
          else            cnt_q   <= cnt_q + 1'b1;
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (rd_valid) begin
            if (last_phase) begin
              state_q <= ST_PICK;
            end else begin
              idx_q   <= idx_q + 1'b1;
              sel_q   <= idx_q + 1'b1;
              state_q <= ST_SET;
            end
          end
        end
        ST_PICK: begin
          sel_q   <= found ? centre : '0;
          state_q <= ST_APPLY;
        end
        ST_APPLY: begin
          if (phase_ack) begin
            done_q  <= 1'b1;
            err_q   <= !found;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phase_cal_sweeper.sv
module phase_cal_sweeper #(
  parameter int PHASES     = 24,
  parameter int PINS       = 8,
  parameter int BEATS      = 8,
  parameter int SETTLE_CYC = 4,
  localparam int PH_W      = $clog2(PHASES),
  localparam int DW        = PINS * BEATS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cal_start,
  output logic            phase_req,
  output logic [PH_W-1:0] phase_sel,
  input  logic            phase_ack,
  output logic            rd_req,
  input  logic            rd_valid,
  input  logic [DW-1:0]   rd_data,
  input  logic [DW-1:0]   exp_pattern,
  output logic            busy,
  output logic            cal_done,
  output logic            cal_error
);

  logic [PINS-1:0]   pin_ok;
  logic [PHASES-1:0] phase_pass;
  logic              win_found;
  logic [PH_W-1:0]   win_centre;
  logic              map_clear;
  logic              map_wr;
  logic [PH_W-1:0]   map_idx;
  logic              ev_ack;
  logic              ev_record;
  logic              sweep_active;

  rsc_compare #(.PINS(PINS), .BEATS(BEATS)) u_cmp (
    .rd_data  (rd_data),
    .exp_data (exp_pattern),
    .pin_ok   (pin_ok)
  );

  rsc_passmap #(.PHASES(PHASES), .PINS(PINS)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (map_clear),
    .wr_en      (map_wr),
    .wr_idx     (map_idx),
    .pin_ok     (pin_ok),
    .phase_pass (phase_pass)
  );

  rsc_window #(.PHASES(PHASES)) u_win (
    .phase_pass (phase_pass),
    .found      (win_found),
    .centre     (win_centre)
  );

  rsc_seq #(.PHASES(PHASES), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (cal_start),
    .phase_ack    (phase_ack),
    .rd_valid     (rd_valid),
    .found        (win_found),
    .centre       (win_centre),
    .phase_req    (phase_req),
    .phase_sel    (phase_sel),
    .rd_req       (rd_req),
    .busy         (busy),
    .done         (cal_done),
    .error        (cal_error),
    .map_clear    (map_clear),
    .map_wr       (map_wr),
    .map_idx      (map_idx),
    .ev_ack       (ev_ack),
    .ev_record    (ev_record),
    .sweep_active (sweep_active)
  );

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int PHASES     = 24,
  parameter int SETTLE_CYC = 4,
  localparam int PH_W      = $clog2(PHASES)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cal_start,
  input logic            phase_req,
  input logic [PH_W-1:0] phase_sel,
  input logic            phase_ack,
  input logic            rd_req,
  input logic            busy,
  input logic            cal_done,
  input logic            cal_error,
  input logic            ev_ack,
  input logic            ev_record,
  input logic            sweep_active
);

  int unsigned since_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             since_ack <= 32'hFFFF;
    else if (ev_ack)        since_ack <= 1;
    else if (since_ack < 32'hFFFF) since_ack <= since_ack + 1;
  end

  assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req && !phase_ack) |=> (phase_req && $stable(phase_sel)));

  assert_settle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (since_ack == SETTLE_CYC + 1));

  assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && phase_req));

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_record_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_record |-> !rd_req && !phase_req && sweep_active);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!busy && !phase_req && !rd_req));

  assert_err_phase0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_error |-> (cal_done && phase_sel == '0));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_active && cal_start) |=> busy);

endmodule

bind phase_cal_sweeper rsc_checker #(
  .PHASES     (PHASES),
  .SETTLE_CYC (SETTLE_CYC)
) u_rsc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cal_start    (cal_start),
  .phase_req    (phase_req),
  .phase_sel    (phase_sel),
  .phase_ack    (phase_ack),
  .rd_req       (rd_req),
  .busy         (busy),
  .cal_done     (cal_done),
  .cal_error    (cal_error),
  .ev_ack       (ev_ack),
  .ev_record    (ev_record),
  .sweep_active (sweep_active)
);

// File: tb/phase_cal_sweeper_bench.sv
module phase_cal_sweeper_bench;

  localparam int PHASES = 24;
  localparam int PINS   = 8;
  localparam int BEATS  = 8;
  localparam int SETTLE = 4;
  localparam int DW     = PINS * BEATS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_tb = 1'b0;
  logic          start_poke = 1'b0;
  logic          cal_start;
  logic          phase_req;
  logic [4:0]    phase_sel;
  logic          phase_ack = 1'b0;
  logic          rd_req;
  logic          rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic [DW-1:0] pattern = 64'h3CA55AC39669_0FF0;
  logic          busy;
  logic          cal_done;
  logic          cal_error;

  assign cal_start = start_tb | start_poke;

  always #4 clk = ~clk;

  phase_cal_sweeper #(.PHASES(PHASES), .PINS(PINS), .BEATS(BEATS), .SETTLE_CYC(SETTLE)) u_phase_cal_sweeper (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
    .phase_req(phase_req), .phase_sel(phase_sel), .phase_ack(phase_ack),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .exp_pattern(pattern),
    .busy(busy), .cal_done(cal_done), .cal_error(cal_error)
  );

  int errors = 0;
  int checks = 0;

  // stimulus model state
  logic [PHASES-1:0] pin_win [PINS];
  int applied = 0;
  int cmd_log [64];
  int cmd_cnt = 0;
  int rd_cnt = 0;
  int bad_gap = 0;
  int neg_cyc = 0;
  int ack_cyc = 0;
  int ack_wait = 0;
  int resp_cd = 0;
  bit stray_en = 0;
  bit stray_pend = 0;
  bit poke_en = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] build_data(input int ph);
    logic [DW-1:0] d;
    d = pattern;
    for (int p = 0; p < PINS; p++)
      if (!pin_win[p][ph]) d[p*BEATS + 4] = ~d[p*BEATS + 4];
    return d;
  endfunction

  function automatic logic [PHASES-1:0] span(input int a, input int b);
    logic [PHASES-1:0] m;
    int i;
    m = '0;
    i = a;
    m[i] = 1'b1;
    while (i != b) begin
      i = (i + 1) % PHASES;
      m[i] = 1'b1;
    end
    return m;
  endfunction

  // expected phase from the requirements: -1 when nothing passes
  function automatic int expect_phase();
    logic [PHASES-1:0] pv;
    int best_len, best_s, len;
    pv = '1;
    for (int p = 0; p < PINS; p++) pv &= pin_win[p];
    if (pv == '0) return -1;
    if (&pv) return (PHASES - 1) / 2;
    best_len = 0;
    best_s = 0;
    for (int s = 0; s < PHASES; s++) begin
      if (pv[s] && !pv[(s + PHASES - 1) % PHASES]) begin
        len = 0;
        while (pv[(s + len) % PHASES]) len++;
        if (len > best_len) begin
          best_len = len;
          best_s = s;
        end
      end
    end
    return (best_s + (best_len - 1) / 2) % PHASES;
  endfunction

  // clock generator and memory models, driven away from the active edge
  always @(negedge clk) begin
    neg_cyc = neg_cyc + 1;
    start_poke = 1'b0;
    rd_valid = 1'b0;
    rd_data = '0;
    if (stray_pend) begin
      rd_valid = 1'b1;
      rd_data = '0;
      stray_pend = 0;
    end
    if (phase_ack) begin
      phase_ack = 1'b0;
    end else if (phase_req && rst_n) begin
      ack_wait++;
      if (ack_wait == 2) begin
        ack_wait = 0;
        phase_ack = 1'b1;
        applied = phase_sel;
        if (cmd_cnt < 64) cmd_log[cmd_cnt] = phase_sel;
        cmd_cnt++;
        ack_cyc = neg_cyc;
        if (stray_en) stray_pend = 1;
      end
    end
    if (rd_req) begin
      rd_cnt++;
      if ((neg_cyc - ack_cyc) != SETTLE + 1) bad_gap++;
      if (phase_req) bad_gap++;
      resp_cd = 3;
    end else if (resp_cd > 0) begin
      resp_cd--;
      if (resp_cd == 0) begin
        rd_valid = 1'b1;
        rd_data = build_data(applied);
        if (poke_en && rd_cnt == PHASES) start_poke = 1'b1;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start_tb = 1'b1;
    @(negedge clk);
    start_tb = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && !cal_done; i++) @(negedge clk);
  endtask

  task automatic clear_counts();
    cmd_cnt = 0;
    rd_cnt = 0;
    bad_gap = 0;
  endtask

  // common judgement after a run
  task automatic judge(input string tag, input int expv);
    bit order_ok;
    int ep;
    ep = (expv < 0) ? 0 : expv;
    order_ok = 1;
    for (int i = 0; i < PHASES; i++) if (cmd_log[i] != i) order_ok = 0;
    chk(cal_done == 1'b1, {tag, " R7 done"}, cal_done, 1);
    chk(busy == 1'b0, {tag, " R7 busy low"}, busy, 0);
    chk(order_ok, {tag, " R2 sweep order"}, order_ok, 1);
    chk(cmd_cnt == PHASES + 1, {tag, " R9 command count"}, cmd_cnt, PHASES + 1);
    chk(rd_cnt == PHASES, {tag, " R3 one read per phase"}, rd_cnt, PHASES);
    chk(bad_gap == 0, {tag, " R3 settle gap"}, bad_gap, 0);
    chk(applied == ep, {tag, " R6 applied phase"}, applied, ep);
    chk(int'(phase_sel) == ep, {tag, " R6 phase_sel"}, phase_sel, ep);
    chk(cal_error == (expv < 0), {tag, " R8 error flag"}, cal_error, expv < 0);
  endtask

  task automatic run_cal(input string tag);
    int e;
    e = expect_phase();
    clear_counts();
    pulse_start();
    chk(busy == 1'b1 && cal_done == 1'b0, {tag, " R2 busy after start"}, busy, 1);
    wait_done();
    judge(tag, e);
  endtask

  task automatic set_all(input logic [PHASES-1:0] m);
    for (int p = 0; p < PINS; p++) pin_win[p] = m;
  endtask

  task automatic t_reset();
    chk(phase_req == 0 && rd_req == 0, "R1 reset requests", {phase_req, rd_req}, 0);
    chk(busy == 0 && cal_done == 0 && cal_error == 0, "R1 reset flags", {busy, cal_done, cal_error}, 0);
    chk(phase_sel == 0, "R1 reset phase", phase_sel, 0);
  endtask

  task automatic t_simple();
    set_all(span(5, 11));          // centre 8
    run_cal("simple");
  endtask

  task automatic t_per_pin();      // R4: one pin narrows and splits the window
    set_all(span(3, 14));
    pin_win[5] = span(6, 12);
    pin_win[2] = span(3, 14) & ~span(8, 8);
    pattern = 64'h9A1F_7E42_C0DE_5B81;
    run_cal("per-pin R4");
  endtask

  task automatic t_wrap();         // R5: run 20..3 crossing the top
    set_all(span(20, 3));
    run_cal("wrap R5");
  endtask

  task automatic t_tie();          // R6: equal runs pick the lower first index
    set_all(span(2, 4) | span(10, 12));
    run_cal("tie R6");
    set_all(span(2, 4) | span(14, 19));
    run_cal("longer R5");
  endtask

  task automatic t_all_pass();
    set_all('1);
    run_cal("all-pass R5");
    repeat (20) @(negedge clk);
    chk(cal_done == 1'b1, "R7 done held", cal_done, 1);
  endtask

  task automatic t_none();
    set_all('0);
    run_cal("none R8");
  endtask

  task automatic t_restart_ignored();  // R9: start mid-sweep and on the last record
    int e;
    set_all(span(7, 16));
    e = expect_phase();
    clear_counts();
    poke_en = 1;
    pulse_start();
    for (int i = 0; i < 2000 && cmd_cnt < 5; i++) @(negedge clk);
    start_tb = 1'b1;
    @(negedge clk);
    start_tb = 1'b0;
    wait_done();
    poke_en = 0;
    judge("restart R9", e);
  endtask

  task automatic t_stray();        // R10: read data during settle must not count
    stray_en = 1;
    set_all(span(5, 11));
    run_cal("stray R10");
    stray_en = 0;
  endtask

  initial begin
    set_all('0);
    for (int i = 0; i < 64; i++) cmd_log[i] = -1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_simple();
    t_per_pin();
    t_wrap();
    t_tie();
    t_all_pass();
    t_none();
    t_restart_ignored();
    t_stray();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule